// File: doc/BRIEF.md
# Dual-Bank Masked Interrupt Controller

This block gathers three level-sensitive interrupt sources and presents them to a processor through two separately masked banks: a normal-priority bank that drives `irqOut` and a fast bank that drives `fiqOut`. Both banks observe the same source levels. Each bank has its own enable mask, and a source reaches a bank's output only when that bank's mask lets it through. Software reads each bank's unmasked and masked views to find out which source needs service.

Software never writes a mask directly. It writes ones to a set location to turn enables on, and ones to a clear location to turn them off, so bits it does not name keep their values. A one-bit software interrupt flag works the same way. The flag is ORed onto source 0 and stays asserted until software clears it.

Access goes through a simple synchronous port. A write takes effect at the rising clock edge where `busSel` and `busWrite` are both high. Read data is combinational and is valid while `busSel` is high and `busWrite` is low. At all other times it reads as zero.

Top module: `dual_bank_intc`

## Requirements
- R1: After reset both enable masks and the software flag are zero, so `irqOut` and `fiqOut` stay low even when every source is high.
- R2: The raw view of the normal bank (offset 0x44) and of the fast bank (offset 0x64) returns `{srcIn[2], srcIn[1], srcIn[0] | softFlag}` in bits 2:0 and zero above.
- R3: The masked view of the normal bank (offset 0x40) and of the fast bank (offset 0x60) returns that bank's raw view ANDed with its enable mask.
- R4: Writing to the set location (0x48 for the normal bank, 0x68 for the fast bank) turns on each enable bit whose bit in `busWdata[2:0]` is 1. Zero bits and bits above bit 2 have no effect. Reading the set location returns the mask.
- R5: Writing to the clear location (0x4C for the normal bank, 0x6C for the fast bank) turns off each enable bit whose write bit is 1. Zero bits have no effect. The clear location reads as zero.
- R6: A write to one bank's mask locations leaves the other bank's mask unchanged.
- R7: `irqOut` is the OR of the normal bank's masked bits, and `fiqOut` is the OR of the fast bank's masked bits.
- R8: Writing 1 in bit 0 at offset 0x50 sets the software flag, and writing 1 in bit 0 at offset 0x54 clears it. Writing 0 has no effect. The flag holds between those writes. Offset 0x50 reads back the flag in bit 0, and offset 0x54 reads as zero.
- R9: Reads of unmapped offsets return zero. Writes to unmapped or read-only offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| busSel | input | 1 | Access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational |
| srcIn | input | 3 | Level-sensitive interrupt sources |
| irqOut | output | 1 | Normal-priority interrupt request |
| fiqOut | output | 1 | Fast interrupt request |

## Verification
The hardest case to reach from the ports is a source level that is present but blocked by one bank and passed by the other. This needs the two masks set to different values, and then `irqOut` and `fiqOut` must be seen to differ for a single source pattern. The stimulus programs the masks in sequence, using zero-bit writes and out-of-range write bits that must change nothing. It then steps `srcIn` through patterns that separate the two banks. The software flag is set with all external sources low, so that only the flag can raise source 0 in the raw view and on the outputs.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NUM_BANK = 2;
  localparam int BANK_IDX_W = 1;

  // Word offsets within the register window; these are decoded behaviour.
  localparam logic [7:0] BANK0_BASE = 8'h40;
  localparam logic [7:0] BANK1_BASE = 8'h60;
  localparam logic [7:0] OFS_MASKED = 8'h00;
  localparam logic [7:0] OFS_RAW    = 8'h04;
  localparam logic [7:0] OFS_EN_SET = 8'h08;
  localparam logic [7:0] OFS_EN_CLR = 8'h0C;
  localparam logic [7:0] SOFT_SET_ADDR = 8'h50;
  localparam logic [7:0] SOFT_CLR_ADDR = 8'h54;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_MASKED,
    RD_RAW,
    RD_ENABLE,
    RD_SOFT
  } rd_sel_e;

  typedef struct packed {
    logic [NUM_BANK-1:0]   enSet;
    logic [NUM_BANK-1:0]   enClr;
    logic                  softSet;
    logic                  softClr;
    rd_sel_e               rdSel;
    logic [BANK_IDX_W-1:0] rdBank;
  } strobe_t;

  function automatic logic [7:0] bankBase(input int b);
    return (b == 0) ? BANK0_BASE : BANK1_BASE;
  endfunction
endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           stb
);
  logic              doWrite;
  logic              doRead;
  logic [NUM_BANK-1:0] hitMasked;
  logic [NUM_BANK-1:0] hitRaw;
  logic [NUM_BANK-1:0] hitSet;
  logic [NUM_BANK-1:0] hitClr;

  assign doWrite = busSel & busWrite;
  assign doRead  = busSel & ~busWrite;

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bankDecode
    localparam logic [7:0] BASE = bankBase(b);
    assign hitMasked[b] = (busAddr == ADDR_W'(BASE + OFS_MASKED));
    assign hitRaw[b]    = (busAddr == ADDR_W'(BASE + OFS_RAW));
    assign hitSet[b]    = (busAddr == ADDR_W'(BASE + OFS_EN_SET));
    assign hitClr[b]    = (busAddr == ADDR_W'(BASE + OFS_EN_CLR));
  end

  always_comb begin
    stb = '0;
    stb.rdSel = RD_NONE;
    stb.enSet = doWrite ? hitSet : '0;
    stb.enClr = doWrite ? hitClr : '0;
    stb.softSet = doWrite & (busAddr == ADDR_W'(SOFT_SET_ADDR));
    stb.softClr = doWrite & (busAddr == ADDR_W'(SOFT_CLR_ADDR));
    if (doRead) begin
      if (busAddr == ADDR_W'(SOFT_SET_ADDR)) begin
        stb.rdSel = RD_SOFT;
      end
      for (int b = 0; b < NUM_BANK; b++) begin
        if (hitMasked[b]) begin
          stb.rdSel = RD_MASKED;
          stb.rdBank = BANK_IDX_W'(b);
        end else if (hitRaw[b]) begin
          stb.rdSel = RD_RAW;
          stb.rdBank = BANK_IDX_W'(b);
        end else if (hitSet[b]) begin
          stb.rdSel = RD_ENABLE;
          stb.rdBank = BANK_IDX_W'(b);
        end
      end
    end
  end

  // At most one state-changing strobe per access (R9: no stray writes).
  assert_single_strobe_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.enSet, stb.enClr, stb.softSet, stb.softClr}));

  // Reads never raise write strobes (R9).
  assert_read_no_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWrite) |-> ({stb.enSet, stb.enClr, stb.softSet, stb.softClr} == '0));
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 3,
  parameter int DATA_W  = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic [DATA_W-1:0]   wData,
  input  logic [NUM_SRC-1:0]  srcIn,
  output logic [DATA_W-1:0]   rData,
  output logic [NUM_BANK-1:0] bankReq
);
  logic                softFlag;
  logic [NUM_SRC-1:0]  rawLevels;
  logic [NUM_SRC-1:0]  wBits;
  logic [NUM_SRC-1:0]  enMask [NUM_BANK];
  logic [NUM_SRC-1:0]  masked [NUM_BANK];

  assign wBits = wData[NUM_SRC-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      softFlag <= 1'b0;
    end else if (stb.softSet && wData[0]) begin
      softFlag <= 1'b1;
    end else if (stb.softClr && wData[0]) begin
      softFlag <= 1'b0;
    end
  end

  assign rawLevels = srcIn | {{(NUM_SRC-1){1'b0}}, softFlag};

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    logic [NUM_SRC-1:0] setBits;
    logic [NUM_SRC-1:0] clrBits;
    assign setBits = stb.enSet[b] ? wBits : '0;
    assign clrBits = stb.enClr[b] ? wBits : '0;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enMask[b] <= '0;
      end else begin
        enMask[b] <= (enMask[b] | setBits) & ~clrBits;
      end
    end

    assign masked[b]  = rawLevels & enMask[b];
    assign bankReq[b] = |masked[b];

    // A set write never drops an enable bit (R4).
    assert_set_keeps_R4: assert property (@(posedge clk) disable iff (!rstN)
      stb.enSet[b] |=> ((enMask[b] & $past(enMask[b])) == $past(enMask[b])));

    // A clear write leaves every named bit off (R5).
    assert_clr_drops_R5: assert property (@(posedge clk) disable iff (!rstN)
      stb.enClr[b] |=> ((enMask[b] & $past(wBits)) == '0));

    // Without a write to this bank the mask holds (R6).
    assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
      !(stb.enSet[b] || stb.enClr[b]) |=> $stable(enMask[b]));

    // A request needs an enabled, active level (R7).
    assert_req_needs_enable_R7: assert property (@(posedge clk) disable iff (!rstN)
      bankReq[b] |-> ((enMask[b] != '0) && (rawLevels != '0)));
  end

  // Flag follows set and clear writes (R8).
  assert_soft_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.softSet && wData[0]) |=> softFlag);
  assert_soft_clr_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.softClr && wData[0]) |=> !softFlag);
  assert_soft_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.softSet || stb.softClr) |=> $stable(softFlag));

  always_comb begin
    rData = '0;
    unique case (stb.rdSel)
      RD_MASKED: rData[NUM_SRC-1:0] = masked[stb.rdBank];
      RD_RAW:    rData[NUM_SRC-1:0] = rawLevels;
      RD_ENABLE: rData[NUM_SRC-1:0] = enMask[stb.rdBank];
      RD_SOFT:   rData[0]           = softFlag;
      default:   rData = '0;
    endcase
  end
endmodule

// File: rtl/dual_bank_intc.sv
module dual_bank_intc
  import intc_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic               irqOut,
  output logic               fiqOut
);
  strobe_t             stb;
  logic [NUM_BANK-1:0] bankReq;

  intc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .stb(stb)
  );

  intc_datapath #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wData(busWdata), .srcIn(srcIn),
    .rData(busRdata), .bankReq(bankReq)
  );

  assign irqOut = bankReq[0];
  assign fiqOut = bankReq[1];

  // Nothing requests while reset holds the masks at zero (R1).
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |-> (!irqOut && !fiqOut));
endmodule

// File: tb/dual_bank_intc_bench.sv
module dual_bank_intc_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [2:0]  srcIn = '0;
  logic        irqOut;
  logic        fiqOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_bank_intc u_dual_bank_intc (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .srcIn(srcIn), .irqOut(irqOut), .fiqOut(fiqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; busWdata = '0;
  endtask

  task automatic rdCheck(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1;
    check(req, busRdata, exp);
    busSel = 1'b0;
  endtask

  task automatic outCheck(input string req, input logic expIrq, input logic expFiq);
    @(negedge clk);
    #1;
    check({req, " irqOut"}, {31'b0, irqOut}, {31'b0, expIrq});
    check({req, " fiqOut"}, {31'b0, fiqOut}, {31'b0, expFiq});
  endtask

  task automatic t_reset();
    srcIn = 3'b111;
    outCheck("R1", 1'b0, 1'b0);
    rdCheck("R1 normal mask", 8'h48, 32'h0);
    rdCheck("R1 fast mask", 8'h68, 32'h0);
    rdCheck("R1 soft flag", 8'h50, 32'h0);
    rdCheck("R2 raw all high", 8'h44, 32'h7);
  endtask

  task automatic t_raw();
    srcIn = 3'b101;
    rdCheck("R2 fast raw", 8'h64, 32'h5);
    srcIn = 3'b010;
    rdCheck("R2 normal raw", 8'h44, 32'h2);
    rdCheck("R3 masked zero mask", 8'h40, 32'h0);
  endtask

  task automatic t_set();
    wr(8'h48, 32'hFFFF_FFF5);
    rdCheck("R4 set upper ignored", 8'h48, 32'h5);
    wr(8'h48, 32'h0);
    rdCheck("R4 zero write no effect", 8'h48, 32'h5);
    rdCheck("R6 fast untouched", 8'h68, 32'h0);
  endtask

  task automatic t_mask();
    srcIn = 3'b011;
    rdCheck("R3 normal masked", 8'h40, 32'h1);
    outCheck("R7 bank split", 1'b1, 1'b0);
    srcIn = 3'b010;
    rdCheck("R3 blocked source", 8'h40, 32'h0);
    outCheck("R7 blocked", 1'b0, 1'b0);
  endtask

  task automatic t_clr();
    wr(8'h4C, 32'h4);
    rdCheck("R5 clear bit2", 8'h48, 32'h1);
    rdCheck("R5 clear reads zero", 8'h4C, 32'h0);
    wr(8'h4C, 32'h0);
    rdCheck("R5 zero clear no effect", 8'h48, 32'h1);
  endtask

  task automatic t_fast();
    wr(8'h68, 32'h2);
    rdCheck("R4 fast set", 8'h68, 32'h2);
    rdCheck("R6 normal untouched", 8'h48, 32'h1);
    srcIn = 3'b010;
    rdCheck("R3 fast masked", 8'h60, 32'h2);
    outCheck("R7 fast only", 1'b0, 1'b1);
    wr(8'h6C, 32'h7);
    rdCheck("R5 fast cleared", 8'h68, 32'h0);
    rdCheck("R6 normal after fast clear", 8'h48, 32'h1);
  endtask

  task automatic t_soft();
    srcIn = 3'b000;
    wr(8'h50, 32'h1);
    rdCheck("R8 soft set", 8'h50, 32'h1);
    rdCheck("R2 soft raw", 8'h44, 32'h1);
    outCheck("R8 soft drives normal", 1'b1, 1'b0);
    repeat (5) @(negedge clk);
    rdCheck("R8 soft held", 8'h50, 32'h1);
    wr(8'h54, 32'h2);
    rdCheck("R8 clear bit0 zero no effect", 8'h50, 32'h1);
    rdCheck("R8 clear loc reads zero", 8'h54, 32'h0);
    wr(8'h54, 32'h1);
    rdCheck("R8 soft cleared", 8'h50, 32'h0);
    outCheck("R8 after clear", 1'b0, 1'b0);
  endtask

  task automatic t_unmapped();
    rdCheck("R9 unmapped 0x58", 8'h58, 32'h0);
    rdCheck("R9 unmapped 0x00", 8'h00, 32'h0);
    wr(8'h44, 32'h7);
    wr(8'h40, 32'h7);
    wr(8'h70, 32'h7);
    wr(8'h49, 32'h7);
    rdCheck("R9 normal mask unchanged", 8'h48, 32'h1);
    rdCheck("R9 fast mask unchanged", 8'h68, 32'h0);
    rdCheck("R9 soft unchanged", 8'h50, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_raw();
    t_set();
    t_mask();
    t_clr();
    t_fast();
    t_soft();
    t_unmapped();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule